// File: doc/BRIEF.md
# Request Tag Association Queue

This block sits on the client side of a requester request stream where the endpoint, not the client, assigns the tags for non-posted requests. Each non-posted request the client sends carries a client-side request ID. When the first beat of such a request is accepted, the block stores that ID in a first-in first-out queue. The endpoint reports the tags it allocated some cycles later, in request order, on two one-cycle lanes. When both lanes fire in the same cycle, lane 0 belongs to the older request.

Each reported tag is bound to the oldest request still waiting for one. The request ID is written into a table with one entry per tag, and the entry is marked valid. Completions can come back in any order. A completion handler presents a tag on the lookup port, reads back the request ID and its valid bit in the same cycle, and can free the entry with a release strobe. Two sticky flags record protocol faults: a tag report that arrives with no request waiting, and a lookup of a tag that is not bound. A pending count shows how many accepted requests are still waiting for a tag.

Top module: `req_tag_binder`

## Requirements
- R1: After a synchronous active-low reset, pending is 0, req_ready is 1, both error flags are 0 and lk_hit is 0 for every tag.
- R2: A request is recorded only on a clock edge where req_valid, req_ready, req_first and req_np are all 1. A beat with req_first=0 or req_np=0 leaves pending unchanged.
- R3: req_ready is 0 while pending equals DEPTH. A beat offered in that state is not recorded.
- R4: A single tag report on lane 0 binds the 8-bit tag to the oldest waiting request ID. From the next cycle, a lookup of that tag returns that ID with lk_hit=1.
- R5: When both lanes report in one cycle, lane 0 binds to the oldest waiting request and lane 1 binds to the next one.
- R6: A report on lane 1 alone is handled as a single report and binds to the oldest waiting request.
- R7: A report that finds no waiting request is dropped and sets underflow_err on the next cycle. With one request waiting and both lanes valid, lane 0 is bound and lane 1 is dropped.
- R8: pending equals requests recorded minus reports bound, and updates one cycle after the edge. A push and a bind on the same edge leave it unchanged.
- R9: lk_id and lk_hit follow lk_tag with no delay. With lk_en=1, lk_release=1 and lk_hit=1, the entry reads lk_hit=0 from the next cycle. A lookup without release leaves the entry valid.
- R10: A lookup with lk_en=1 on a tag whose lk_hit is 0 sets miss_err on the next cycle. A read with lk_en=0 does not set it.
- R11: When a report binds a tag in the same cycle that the tag is released, the bind wins. When both lanes carry the same tag, lane 1's request ID is kept.
- R12: underflow_err and miss_err stay 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request stream beat valid |
| req_first | input | 1 | Beat is the first beat of a request |
| req_np | input | 1 | Request is non-posted |
| req_id | input | ID_W | Client-side request ID |
| req_ready | output | 1 | Request stream ready; low when the queue is full |
| tag_vld0 | input | 1 | Lane 0 tag report strobe |
| tag0 | input | 8 | Lane 0 tag |
| tag_vld1 | input | 1 | Lane 1 tag report strobe |
| tag1 | input | 8 | Lane 1 tag |
| lk_tag | input | 8 | Completion lookup tag |
| lk_en | input | 1 | Lookup is a real completion access |
| lk_release | input | 1 | Free the looked-up entry |
| lk_id | output | ID_W | Request ID stored for lk_tag |
| lk_hit | output | 1 | Entry for lk_tag is bound |
| pending | output | $clog2(DEPTH)+1 | Requests waiting for a tag |
| underflow_err | output | 1 | Sticky: tag report with no waiting request |
| miss_err | output | 1 | Sticky: lookup of an unbound tag |

## Verification
A queue pointer that is off by one shows up as the wrong ID on lk_id one cycle after the bind, so every bind is followed by a read of that tag. A count error shows in pending on the next cycle and, near the limit, as req_ready going low at the wrong time. Lane age order, a wrong winner when both lanes carry the same tag, and a wrong winner between a write and a release in the same cycle all leave the wrong ID or hit bit on the table the cycle after. The bench therefore reads each affected tag right after the edge.

// File: rtl/tagq_pkg.sv
// Shared constants for the request tag association queue.
// Assumes an 8-bit tag space fully indexed by the lookup table.
package tagq_pkg;
    localparam int TAG_W    = 8;
    localparam int NUM_TAGS = 1 << TAG_W;
endpackage

// File: rtl/req_id_fifo.sv
// Request ID queue: one push and up to two pops per cycle.
// Provides the oldest and second-oldest entries combinationally.
// Assumes DEPTH is a power of two >= 2 and that the caller never pops
// more entries than count holds.
module req_id_fifo #(
    parameter int DEPTH = 32,
    parameter int ID_W  = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic [1:0]      pop_n,
    output logic [ID_W-1:0] head0,
    output logic [ID_W-1:0] head1,
    output logic [CW-1:0]   count,
    output logic            full
);
    logic [ID_W-1:0] mem [DEPTH];
    logic [AW-1:0]   wr_ptr;
    logic [AW-1:0]   rd_ptr;
    logic            push_ok;

    assign full    = (count == CW'(DEPTH));
    assign push_ok = push && !full;
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_ptr + AW'(1)];

    // Store the pushed ID at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_id;
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + AW'(1);
            rd_ptr <= rd_ptr + AW'(pop_n);
            count  <= count + CW'(push_ok) - CW'(pop_n);
        end
    end

    assert_pop_le_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        CW'(pop_n) <= count);
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
endmodule

// File: rtl/tag_bind_table.sv
// Tag-indexed table of request IDs with a valid bit per tag.
// Two write lanes and one release per cycle. When lanes collide, lane 1
// wins over lane 0, and both win over a release of the same tag.
// Reads are combinational.
module tag_bind_table #(
    parameter int ID_W  = 8,
    localparam int TW   = tagq_pkg::TAG_W,
    localparam int NT   = tagq_pkg::NUM_TAGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr0_en,
    input  logic [TW-1:0]   wr0_tag,
    input  logic [ID_W-1:0] wr0_id,
    input  logic            wr1_en,
    input  logic [TW-1:0]   wr1_tag,
    input  logic [ID_W-1:0] wr1_id,
    input  logic            rel_en,
    input  logic [TW-1:0]   rel_tag,
    input  logic [TW-1:0]   rd_tag,
    output logic [ID_W-1:0] rd_id,
    output logic            rd_hit
);
    logic [ID_W-1:0] ids [NT];
    logic [NT-1:0]   bound;

    assign rd_id  = ids[rd_tag];
    assign rd_hit = bound[rd_tag];

    // Write IDs; lane 1 is written last so it wins on the same tag.
    always_ff @(posedge clk) begin
        if (wr0_en) ids[wr0_tag] <= wr0_id;
        if (wr1_en) ids[wr1_tag] <= wr1_id;
    end

    // Maintain valid bits; a release is applied before the binds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bound <= '0;
        end else begin
            if (rel_en) bound[rel_tag] <= 1'b0;
            if (wr0_en) bound[wr0_tag] <= 1'b1;
            if (wr1_en) bound[wr1_tag] <= 1'b1;
        end
    end

    assert_bind_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr0_en |=> bound[$past(wr0_tag)]);
    assert_lane1_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr1_en |=> bound[$past(wr1_tag)]);
    assert_release_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_en && !(wr0_en && wr0_tag == rel_tag) && !(wr1_en && wr1_tag == rel_tag))
        |=> !bound[$past(rel_tag)]);
endmodule

// File: rtl/req_tag_binder.sv
// Request tag association queue top.
// Queues the IDs of accepted non-posted requests and binds each tag the
// endpoint reports (two lanes, lane 0 older) to the oldest waiting ID.
// Keeps a tag-indexed lookup for completions and sticky fault flags.
// Assumes tag reports arrive in request order.
module req_tag_binder #(
    parameter int ID_W  = 8,
    parameter int DEPTH = 32,
    localparam int TW   = tagq_pkg::TAG_W,
    localparam int CW   = $clog2(DEPTH) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_first,
    input  logic            req_np,
    input  logic [ID_W-1:0] req_id,
    output logic            req_ready,
    input  logic            tag_vld0,
    input  logic [TW-1:0]   tag0,
    input  logic            tag_vld1,
    input  logic [TW-1:0]   tag1,
    input  logic [TW-1:0]   lk_tag,
    input  logic            lk_en,
    input  logic            lk_release,
    output logic [ID_W-1:0] lk_id,
    output logic            lk_hit,
    output logic [CW-1:0]   pending,
    output logic            underflow_err,
    output logic            miss_err
);
    logic            q_full;
    logic            req_push;
    logic [ID_W-1:0] head0;
    logic [ID_W-1:0] head1;
    logic            wr0_en;
    logic            wr1_en;
    logic [ID_W-1:0] wr1_id;
    logic [1:0]      pop_n;
    logic            drop;
    logic            rel_en;

    assign req_ready = !q_full;
    assign req_push  = req_valid && req_ready && req_first && req_np;

    // Match reports to queue entries in age order: lane 0 first.
    always_comb begin
        wr0_en = tag_vld0 && (pending != '0);
        if (tag_vld0) begin
            wr1_en = tag_vld1 && (pending >= CW'(2));
            wr1_id = head1;
        end else begin
            wr1_en = tag_vld1 && (pending != '0);
            wr1_id = head0;
        end
        pop_n = {1'b0, wr0_en} + {1'b0, wr1_en};
        drop  = (tag_vld0 && !wr0_en) || (tag_vld1 && !wr1_en);
    end

    assign rel_en = lk_en && lk_release && lk_hit;

    req_id_fifo #(.DEPTH(DEPTH), .ID_W(ID_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (req_push),
        .push_id (req_id),
        .pop_n   (pop_n),
        .head0   (head0),
        .head1   (head1),
        .count   (pending),
        .full    (q_full)
    );

    tag_bind_table #(.ID_W(ID_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr0_en  (wr0_en),
        .wr0_tag (tag0),
        .wr0_id  (head0),
        .wr1_en  (wr1_en),
        .wr1_tag (tag1),
        .wr1_id  (wr1_id),
        .rel_en  (rel_en),
        .rel_tag (lk_tag),
        .rd_tag  (lk_tag),
        .rd_id   (lk_id),
        .rd_hit  (lk_hit)
    );

    // Sticky fault flags, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            underflow_err <= 1'b0;
            miss_err      <= 1'b0;
        end else begin
            if (drop)             underflow_err <= 1'b1;
            if (lk_en && !lk_hit) miss_err      <= 1'b1;
        end
    end

    assert_ready_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pending == CW'(DEPTH)) |-> !req_ready);
    assert_push_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_push && !tag_vld0 && !tag_vld1) |=> pending == $past(pending) + CW'(1));
    assert_empty_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_vld0 && pending == '0) |=> underflow_err);
    assert_sticky_underflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
        underflow_err |=> underflow_err);
    assert_sticky_miss_R12: assert property (@(posedge clk) disable iff (!rst_n)
        miss_err |=> miss_err);
    assert_miss_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !lk_hit) |=> miss_err);
endmodule

// File: tb/req_tag_binder_bench.sv
module req_tag_binder_bench;
    localparam int ID_W = 8;
    localparam int DEPTH = 32;
    localparam int CW = $clog2(DEPTH) + 1;

    typedef struct packed {
        logic       push;
        logic [7:0] id;
        logic       v0;
        logic [7:0] t0;
        logic       v1;
        logic [7:0] t1;
        logic [5:0] exp_pend;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 6'd1},
        '{1'b1, 8'h22, 1'b0, 8'h00, 1'b0, 8'h00, 6'd2},
        '{1'b1, 8'h33, 1'b1, 8'h05, 1'b0, 8'h00, 6'd2},
        '{1'b0, 8'h00, 1'b1, 8'h07, 1'b1, 8'h09, 6'd0},
        '{1'b1, 8'h44, 1'b0, 8'h00, 1'b0, 8'h00, 6'd1},
        '{1'b1, 8'h55, 1'b0, 8'h00, 1'b0, 8'h00, 6'd2},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b1, 8'hFF, 6'd1},
        '{1'b0, 8'h00, 1'b0, 8'h00, 1'b0, 8'h00, 6'd1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_first = 1'b0, req_np = 1'b0;
    logic [ID_W-1:0] req_id = '0;
    logic req_ready;
    logic tag_vld0 = 1'b0, tag_vld1 = 1'b0;
    logic [7:0] tag0 = '0, tag1 = '0, lk_tag = '0;
    logic lk_en = 1'b0, lk_release = 1'b0;
    logic [ID_W-1:0] lk_id;
    logic lk_hit;
    logic [CW-1:0] pending;
    logic underflow_err, miss_err;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    req_tag_binder #(.ID_W(ID_W), .DEPTH(DEPTH)) u_req_tag_binder (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_first(req_first), .req_np(req_np),
        .req_id(req_id), .req_ready(req_ready),
        .tag_vld0(tag_vld0), .tag0(tag0), .tag_vld1(tag_vld1), .tag1(tag1),
        .lk_tag(lk_tag), .lk_en(lk_en), .lk_release(lk_release),
        .lk_id(lk_id), .lk_hit(lk_hit), .pending(pending),
        .underflow_err(underflow_err), .miss_err(miss_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        req_valid = 1'b0; tag_vld0 = 1'b0; tag_vld1 = 1'b0;
        lk_en = 1'b0; lk_release = 1'b0;
    endtask

    task automatic push(input logic [7:0] id);
        req_valid = 1'b1; req_first = 1'b1; req_np = 1'b1; req_id = id;
        cyc();
    endtask

    task automatic peek(input string req, input logic [7:0] t,
                        input int exp_hit, input int exp_id);
        lk_tag = t;
        #1;
        chk({req, " hit"}, int'(lk_hit), exp_hit);
        if (exp_hit != 0) chk({req, " id"}, int'(lk_id), exp_id);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 pending", int'(pending), 0);
        chk("R1 ready", int'(req_ready), 1);
        chk("R1 uflow", int'(underflow_err), 0);
        chk("R1 miss", int'(miss_err), 0);
        peek("R1", 8'h05, 0, 0);

        // Vector walk: R4 R5 R6 R8
        for (int i = 0; i < 8; i++) begin
            req_valid = VEC[i].push; req_first = 1'b1; req_np = 1'b1;
            req_id = VEC[i].id;
            tag_vld0 = VEC[i].v0; tag0 = VEC[i].t0;
            tag_vld1 = VEC[i].v1; tag1 = VEC[i].t1;
            cyc();
            chk("R8 pending", int'(pending), int'(VEC[i].exp_pend));
        end
        peek("R4 tag5", 8'h05, 1, 8'h11);
        peek("R5 lane0", 8'h07, 1, 8'h22);
        peek("R5 lane1", 8'h09, 1, 8'h33);
        peek("R6 lane1 only", 8'hFF, 1, 8'h44);

        // R2 beats that must not push
        req_valid = 1'b1; req_first = 1'b0; req_np = 1'b1; req_id = 8'hA0;
        cyc();
        chk("R2 nonfirst", int'(pending), 1);
        req_valid = 1'b1; req_first = 1'b1; req_np = 1'b0; req_id = 8'hA1;
        cyc();
        chk("R2 posted", int'(pending), 1);
        chk("R7 uflow before", int'(underflow_err), 0);

        // R7 partial underflow: one waiting, both lanes
        tag_vld0 = 1'b1; tag0 = 8'd20; tag_vld1 = 1'b1; tag1 = 8'd21;
        cyc();
        chk("R7 pending", int'(pending), 0);
        chk("R7 uflow", int'(underflow_err), 1);
        peek("R7 lane0 bound", 8'd20, 1, 8'h55);
        peek("R7 lane1 dropped", 8'd21, 0, 0);
        chk("R10 no miss on passive read", int'(miss_err), 0);

        // R9 release and plain lookup
        lk_tag = 8'h05; lk_en = 1'b1; lk_release = 1'b1;
        cyc();
        peek("R9 released", 8'h05, 0, 0);
        lk_tag = 8'h07; lk_en = 1'b1;
        cyc();
        peek("R9 kept", 8'h07, 1, 8'h22);
        chk("R10 no miss on hit", int'(miss_err), 0);

        // R10 miss on unbound lookup
        lk_tag = 8'h05; lk_en = 1'b1;
        cyc();
        chk("R10 miss", int'(miss_err), 1);

        // R3 full queue
        for (int i = 0; i < DEPTH; i++) push(8'(8'h80 + i));
        chk("R3 pending full", int'(pending), DEPTH);
        chk("R3 ready low", int'(req_ready), 0);
        push(8'hEE);
        chk("R3 no push when full", int'(pending), DEPTH);
        tag_vld0 = 1'b1; tag0 = 8'd30; tag_vld1 = 1'b1; tag1 = 8'd31;
        cyc();
        chk("R8 dual pop", int'(pending), DEPTH - 2);
        chk("R3 ready back", int'(req_ready), 1);
        peek("R5 full lane0", 8'd30, 1, 8'h80);
        peek("R5 full lane1", 8'd31, 1, 8'h81);

        // R11 same tag on both lanes
        tag_vld0 = 1'b1; tag0 = 8'd40; tag_vld1 = 1'b1; tag1 = 8'd40;
        cyc();
        peek("R11 lane1 wins", 8'd40, 1, 8'h83);

        // R11 bind beats release; R8 push with pop
        lk_tag = 8'd30; lk_en = 1'b1; lk_release = 1'b1;
        tag_vld0 = 1'b1; tag0 = 8'd30;
        cyc();
        peek("R11 bind over release", 8'd30, 1, 8'h84);
        req_valid = 1'b1; req_first = 1'b1; req_np = 1'b1; req_id = 8'h99;
        tag_vld0 = 1'b1; tag0 = 8'd41;
        cyc();
        chk("R8 push and pop", int'(pending), DEPTH - 5);
        peek("R4 after push+pop", 8'd41, 1, 8'h85);

        // R12 flags still set
        chk("R12 uflow sticky", int'(underflow_err), 1);
        chk("R12 miss sticky", int'(miss_err), 1);

        // R1 reset again
        rst_n = 1'b0;
        cyc();
        rst_n = 1'b1;
        chk("R1 pending after reset", int'(pending), 0);
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R12 uflow reset", int'(underflow_err), 0);
        chk("R12 miss reset", int'(miss_err), 0);
        peek("R1 table cleared", 8'h07, 0, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule